// File: doc/BRIEF.md
# Stop-Mode Wake-Up Delay Sequencer

This block controls the low-power stop sequence of a processor core. A one-cycle stop request from instruction decode gates the core clock phases and, unless the external wake line is already high, switches off the oscillator. A wake on the external interrupt line passes through a synchronizer and a fixed qualification window. The block then runs a clock-stabilization countdown, whose length is chosen by a configuration input, before it hands the clock phases back to the core with a one-cycle resume pulse. While that countdown runs, the block drives a clear mask to the interrupt controller. The mask flushes every pending request except trace and stack-error. When the PLL was off at stop entry, the resume also waits for the lock input.

There are five states. RUN is the normal operating state. STOP_OSC_OFF covers the 32-cycle stop instruction and then the wait for a wake. SYNC is a 3-cycle window for the wake line. DELAY is the stabilization countdown. RESUME lasts one cycle. The transitions are:

- RUN to STOP_OSC_OFF on a stop request.
- RUN to SYNC on a wake-line rising edge, but only in the first use after reset.
- STOP_OSC_OFF to SYNC once the instruction count is done and the synchronized wake line is high.
- SYNC to DELAY when the window ends. The countdown length is loaded at this point.
- DELAY to RESUME when the countdown reaches zero and the PLL lock wait, if any, is satisfied.
- RESUME to RUN unconditionally.

A reset from any state returns at once to RUN, with the clock phases enabled.

If the synchronized wake line is already high when the stop request arrives, the oscillator stays on. The stop then acts as a timed no-operation lasting 35 cycles plus the countdown.

Top module: `stop_wake_seq`

## Requirements
- R1: When reset is released, `phase_en`=1, `osc_en`=1, `resume`=0 and `irq_clr`=0.
- R2: A stop request in RUN makes `phase_en` 0 from the next cycle. If the synchronized wake line was low at that edge, `osc_en` is also 0 until the wake is seen.
- R3: If the synchronized wake line is high at the stop-request edge, `osc_en` stays 1 throughout. `resume` rises exactly 35+D clock edges after the request edge, where D is the countdown length (51 edges in short mode).
- R4: D is 16 when `long_delay`=0 and 131072 when `long_delay`=1. The input is sampled at the SYNC-to-DELAY transition.
- R5: The wake line passes through 3 synchronizer flops and then a 3-cycle SYNC window. From a cold stop whose instruction count is done, `resume` appears in the cycle after the 7+D-th edge, counting the edge that first samples the wake line as edge 1.
- R6: During SYNC and DELAY, `irq_clr` equals the inverse of the keep mask. With defaults this is 8'hFC: bit 0 is trace and bit 1 is stack error, and both are preserved. `irq_clr` is 0 in the same cycle `resume` is 1.
- R7: `resume` is high for exactly one cycle, and `phase_en` is 1 from that cycle on.
- R8: While reset is asserted, `irq_clr` is all ones. A reset during stop returns straight to RUN with `phase_en`=1, with no countdown and no `resume` pulse.
- R9: In the first use after reset, a wake-line pulse of 2 cycles starts the SYNC/DELAY sequence from RUN. Phases are gated and `resume` follows at edge 7+D.
- R10: If `pll_off` was 1 at the stop-request edge, DELAY does not end before `pll_locked` is 1. If `pll_off` was 0, `pll_locked` has no effect.
- R11: Wake-line edges and stop requests that arrive during SYNC or DELAY do not change the resume timing and do not start a new stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle stop request from decode |
| long_delay | input | 1 | 1 selects the long countdown, 0 the short one |
| pll_off | input | 1 | PLL is disabled at stop entry |
| pll_locked | input | 1 | PLL lock indication |
| irqa | input | 1 | Asynchronous external wake interrupt line |
| phase_en | output | 1 | Core clock-phase enable |
| osc_en | output | 1 | Oscillator run enable |
| irq_clr | output | IRQ_W | Per-source clear mask to the interrupt controller |
| resume | output | 1 | One-cycle resume pulse |

## Verification
The cycle count from the request to `resume` is measured for four patterns:

- A hot stop, with the wake line high before the request. This separates the 35-cycle overhead from the countdown.
- A cold stop woken later. This isolates the synchronizer plus SYNC latency.
- A post-reset wake pulse, which shows the armed path in RUN.
- A hot stop in long mode, which shows that the mode bit changes only the countdown.

PLL cases raise lock before and after the countdown ends, and also hold it low with the PLL left on. This separates a lock-wait extension from unconditional waiting. A glitch pattern toggles the wake line and pulses a stop request during DELAY; it must leave the timing unchanged.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_STOP_OSC_OFF,
        ST_SYNC,
        ST_DELAY,
        ST_RESUME
    } wake_state_t;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync,
    output logic line_rise
);
    logic [STAGES-1:0] chain;
    logic              held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            held  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], line_async};
            held  <= chain[STAGES-1];
        end
    end

    assign line_sync = chain[STAGES-1];
    assign line_rise = chain[STAGES-1] & ~held;
endmodule

// File: rtl/wake_down_counter.sv
module wake_down_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             count_en,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (count_en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_zero = (cnt == '0);
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
    import stop_wake_pkg::*;
#(
    parameter int               IRQ_W            = 8,
    parameter logic [IRQ_W-1:0] KEEP_MASK        = 'h3,
    parameter int               LONG_CYCLES      = 131072,
    parameter int               SHORT_CYCLES     = 16,
    parameter int               STOP_INSN_CYCLES = 32,
    parameter int               SYNC_CYCLES      = 3,
    parameter int               SYNC_STAGES      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             long_delay,
    input  logic             pll_off,
    input  logic             pll_locked,
    input  logic             irqa,
    output logic             phase_en,
    output logic             osc_en,
    output logic [IRQ_W-1:0] irq_clr,
    output logic             resume
);
    localparam int               CNT_W   = $clog2(LONG_CYCLES);
    localparam logic [CNT_W-1:0] INSN_LD = CNT_W'(STOP_INSN_CYCLES - 1);
    localparam logic [CNT_W-1:0] SYNC_LD = CNT_W'(SYNC_CYCLES - 1);
    localparam logic [CNT_W-1:0] LONG_LD = CNT_W'(LONG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHRT_LD = CNT_W'(SHORT_CYCLES - 1);

    wake_state_t      state, nxt;
    logic             irqa_s, irqa_rise;
    logic             cnt_zero, cnt_load, cnt_en;
    logic [CNT_W-1:0] cnt_val;
    logic             hot, pll_wait, armed;

    irq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (irqa),
        .line_sync  (irqa_s),
        .line_rise  (irqa_rise)
    );

    wake_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .count_en (cnt_en),
        .at_zero  (cnt_zero)
    );

    // Next-state and counter-load decisions
    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_RUN: begin
                if (stop_req) begin
                    nxt      = ST_STOP_OSC_OFF;
                    cnt_load = 1'b1;
                    cnt_val  = INSN_LD;
                end else if (armed && irqa_rise) begin
                    nxt      = ST_SYNC;
                    cnt_load = 1'b1;
                    cnt_val  = SYNC_LD;
                end
            end
            ST_STOP_OSC_OFF: begin
                if (cnt_zero && irqa_s) begin
                    nxt      = ST_SYNC;
                    cnt_load = 1'b1;
                    cnt_val  = SYNC_LD;
                end
            end
            ST_SYNC: begin
                if (cnt_zero) begin
                    nxt      = ST_DELAY;
                    cnt_load = 1'b1;
                    cnt_val  = long_delay ? LONG_LD : SHRT_LD;
                end
            end
            ST_DELAY: begin
                if (cnt_zero && (!pll_wait || pll_locked)) begin
                    nxt = ST_RESUME;
                end
            end
            ST_RESUME: nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    assign cnt_en = (state != ST_RUN) && (state != ST_RESUME);

    // State register and entry flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            hot      <= 1'b0;
            pll_wait <= 1'b0;
            armed    <= 1'b1;
        end else begin
            state <= nxt;
            if (state == ST_RUN && stop_req) begin
                hot      <= irqa_s;
                pll_wait <= pll_off;
                armed    <= 1'b0;
            end else if (state == ST_RUN && armed && irqa_rise) begin
                armed <= 1'b0;
            end
        end
    end

    // Moore outputs
    always_comb begin
        phase_en = (state == ST_RUN) || (state == ST_RESUME);
        osc_en   = !(state == ST_STOP_OSC_OFF && !hot);
        resume   = (state == ST_RESUME);
        if (!rst_n) begin
            irq_clr = '1;
        end else if (state == ST_SYNC || state == ST_DELAY) begin
            irq_clr = ~KEEP_MASK;
        end else begin
            irq_clr = '0;
        end
    end

    assert_hot_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && irqa_s) |=> osc_en);

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (irq_clr == '0) && $past(irq_clr == ~KEEP_MASK));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    assert_lock_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && pll_wait) |-> $past(pll_locked));

    assert_delay_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && !cnt_zero) |=> (state == ST_DELAY));
endmodule

// File: tb/tb_stop_wake_seq.sv
`timescale 1ns/1ps
module tb_stop_wake_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0, long_delay = 1'b0, pll_off = 1'b0;
    logic       pll_locked = 1'b0, irqa = 1'b0;
    logic       phase_en, osc_en, resume;
    logic [7:0] irq_clr;

    int  checks = 0, fails = 0, cyc = 0;
    int  lock_at = 0, pulse_end = 0, mid_phase_at = 0;
    bit  glitch = 0, chk_osc = 0, osc_bad = 0, mid_phase = 0;

    typedef struct packed {
        logic        hot;
        logic        pll;
        logic        glt;
        logic [7:0]  lock;
        logic [17:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 1'b0, 8'd0,  18'd52},
        '{1'b0, 1'b0, 1'b0, 8'd0,  18'd23},
        '{1'b1, 1'b1, 1'b0, 8'd60, 18'd61},
        '{1'b1, 1'b1, 1'b0, 8'd10, 18'd52},
        '{1'b1, 1'b0, 1'b0, 8'd0,  18'd52},
        '{1'b0, 1'b0, 1'b1, 8'd0,  18'd23}
    };

    always #2 clk = ~clk;

    stop_wake_seq dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .long_delay(long_delay),
        .pll_off(pll_off), .pll_locked(pll_locked), .irqa(irqa),
        .phase_en(phase_en), .osc_en(osc_en), .irq_clr(irq_clr), .resume(resume)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts edges from the next posedge (edge 1) until resume is seen
    task automatic measure(input int exp, input string req);
        int   n = 0;
        logic [7:0] prev_clr = '0;
        for (int i = 0; i < 140000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) stop_req = 1'b0;
            if (n == pulse_end) irqa = 1'b0;
            if (n == lock_at) pll_locked = 1'b1;
            if (n == mid_phase_at) mid_phase = phase_en;
            if (glitch) begin
                if (n == 10) irqa = 1'b0;
                if (n == 13) irqa = 1'b1;
                if (n == 15) stop_req = 1'b1;
                if (n == 16) stop_req = 1'b0;
            end
            if (chk_osc && !osc_en) osc_bad = 1;
            if (resume) break;
            prev_clr = irq_clr;
        end
        check(n == exp, req, n, exp);
        check(irq_clr == 8'h00 && prev_clr == 8'hFC, "R6", {prev_clr, irq_clr}, 16'hFC00);
        @(negedge clk);
        check(!resume && phase_en, "R7", {resume, phase_en}, 1);
    endtask

    initial begin
        for (;;) begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        // R8: clear mask during reset, R1: state after release
        wait_cycles(2);
        check(irq_clr == 8'hFF, "R8", irq_clr, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check(phase_en && osc_en && !resume && irq_clr == 8'h00, "R1",
              {phase_en, osc_en, resume, irq_clr}, 11'h600);

        // R9: a 2-cycle wake pulse after reset starts the sequence
        irqa = 1'b1;
        pulse_end = 2;
        mid_phase_at = 10;
        measure(23, "R9");
        check(mid_phase == 1'b0, "R9", mid_phase, 0);
        pulse_end = 0;
        mid_phase_at = 0;
        wait_cycles(6);

        // Vector table: short mode, hot/cold, PLL wait, glitches
        foreach (VECS[k]) begin
            pll_locked = 1'b0;
            lock_at    = int'(VECS[k].lock);
            pll_off    = VECS[k].pll;
            glitch     = VECS[k].glt;
            osc_bad    = 0;
            if (VECS[k].hot) begin
                irqa = 1'b1;
                wait_cycles(5);
                chk_osc  = 1;
                stop_req = 1'b1;
                measure(int'(VECS[k].exp), VECS[k].pll ? "R10" : "R3");
                check(!osc_bad, "R3", osc_bad, 0);
            end else begin
                chk_osc  = 0;
                stop_req = 1'b1;
                @(negedge clk);
                stop_req = 1'b0;
                wait_cycles(40);
                check(!osc_en && !phase_en, "R2", {osc_en, phase_en}, 0);
                irqa = 1'b1;
                measure(int'(VECS[k].exp), VECS[k].glt ? "R11" : "R5");
                if (VECS[k].glt) begin
                    irqa = 1'b0;
                    osc_bad = 0;
                    for (int j = 0; j < 10; j++) begin
                        @(negedge clk);
                        if (!phase_en) osc_bad = 1;
                    end
                    check(!osc_bad, "R11", osc_bad, 0);
                end
            end
            irqa    = 1'b0;
            pll_off = 1'b0;
            glitch  = 0;
            chk_osc = 0;
            wait_cycles(8);
        end
        lock_at = 0;

        // R4: long countdown on a hot stop
        long_delay = 1'b1;
        irqa = 1'b1;
        wait_cycles(5);
        stop_req = 1'b1;
        measure(131108, "R4");
        irqa = 1'b0;
        long_delay = 1'b0;
        wait_cycles(8);

        // R8: reset during stop skips the countdown
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wait_cycles(40);
        irqa = 1'b1;
        wait_cycles(8);
        rst_n = 1'b0;
        #1;
        check(irq_clr == 8'hFF && phase_en, "R8", {irq_clr, phase_en}, 9'h1FF);
        irqa = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        osc_bad = 0;
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if (resume || !phase_en) osc_bad = 1;
        end
        check(!osc_bad && osc_en, "R8", osc_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule